// File: doc/BRIEF.md
# Programmed Operator Trap Sequencer

This block watches each fetched 24-bit instruction word for the programmed-operator tag. A programmed operator is an instruction that software emulates, so hardware does not execute it. When the tag is found, the block runs a fixed two-cycle trap.

- **Link cycle.** The block writes a return-linkage word to memory location zero. It also clears the overflow indicator and, for a system call, switches the processor into monitor mode.
- **Jump cycle.** The block loads the program counter with a vector slot in the range octal 100 to 177. The slot is chosen by the instruction's six-bit operator number.

The linkage word holds three things. The low bits carry the address of the trapping instruction. The most significant bit carries the overflow state as it was when the trap started. Bit 14 is a forced indirect marker, so the service routine can reach the trapping instruction's operand through one indirection.

Bit positions are given in two ways. The instruction format numbers bits from the most significant end, so format bit 0 is vector bit 23. In this brief, bit indices refer to the Verilog vector.

A system call is a tagged instruction whose top bit is also set while the processor is in user mode. Its linkage write is strobed as physical, so the address map skips translation. Ordinary operators in every mode use the virtual path. While the block is busy, fetch is stalled and new instructions are ignored. The return from the service routine is handled elsewhere.

Top module: `pop_trap_seq`

## Requirements
- R1: A trap starts on a clock edge where `instr_valid` is 1, `busy` is 0 and `instr[21]` is 1. `busy` goes high right after that edge.
- R2: In the first cycle after the start, `mem_we` is 1 and `mem_addr` is 0. `mem_wdata[13:0]` holds the `pc_in` value that was sampled at the start edge.
- R3: In that link cycle, `mem_wdata[23]` equals the `ovf_in` value sampled at the start edge, and `ovf_clr` is 1 for exactly that cycle.
- R4: In the link cycle, `mem_wdata[14]` is 1 and `mem_wdata[22:15]` is 0. Whenever `mem_we` is 0, `mem_wdata` is 0.
- R5: In the cycle after the link cycle, `pc_load` is 1 and `pc_next` equals 64 plus `instr[20:15]` of the trapping instruction. Whenever `pc_load` is 0, `pc_next` is 0.
- R6: A system call is a trap where `mode_in` = 2'b10 (user) and `instr[23]` = 1 at the start edge. Its link cycle has `mode_load` = 1, `mode_out` = 2'b01 (monitor) and `mem_phys` = 1.
- R7: Every other trap leaves `mode_load`, `mode_out` and `mem_phys` at 0. This covers user mode with `instr[23]` = 0, and modes 2'b00 (normal), 2'b01 (monitor) and 2'b11 (treated as normal) whatever `instr[23]` is.
- R8: `busy` stays high for exactly two cycles. `instr_valid` has no effect while `busy` is high, so back-to-back traps are spaced at least two cycles apart.
- R9: An instruction with `instr[21]` = 0 causes no strobe and does not raise `busy`, whatever the values of `instr[23]` and `mode_in`.
- R10: After reset, `busy` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Fetched instruction is present |
| instr | input | 24 | Fetched instruction word |
| pc_in | input | 14 | Address of the fetched instruction |
| ovf_in | input | 1 | Current overflow indicator |
| mode_in | input | 2 | Current mode: 00 normal, 01 monitor, 10 user, 11 normal |
| busy | output | 1 | Trap in progress; stalls fetch |
| mem_we | output | 1 | Linkage write strobe |
| mem_addr | output | 14 | Linkage write address, always zero |
| mem_wdata | output | 24 | Linkage word |
| mem_phys | output | 1 | Write bypasses address translation |
| ovf_clr | output | 1 | Clear the overflow indicator |
| mode_load | output | 1 | Load a new mode |
| mode_out | output | 2 | New mode value |
| pc_load | output | 1 | Load the program counter |
| pc_next | output | 14 | Vector slot address |

## Verification
The bench builds the block with its default parameters: a 14-bit program counter, a 6-bit operator number and a vector base of 64. With these values, every vector slot from 64 to 127 can be reached, including both ends. Directed sequences cover all four mode encodings, each with the top instruction bit both set and clear. Further sequences cover requests offered during both busy cycles and traps issued back to back. A long pseudorandom run then drives all combinations of tag bits, overflow and mode against a behavioural reference model.

// File: rtl/pop_trap_pkg.sv
package pop_trap_pkg;

  // Instruction word is numbered big-endian in its format; these are
  // the vector indices of the fields that drive behaviour.
  localparam int WORD_W   = 24;
  localparam int TAG_SYS  = 23;  // format bit 0
  localparam int TAG_POP  = 21;  // format bit 2
  localparam int OPC_LSB  = 15;  // format bits 3..8
  localparam int IND_BIT  = 14;  // format bit 9 of the linkage word

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_MONITOR = 2'b01,
    MODE_USER    = 2'b10,
    MODE_RSVD    = 2'b11
  } cpu_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_LINK = 2'b01,
    PH_JUMP = 2'b10
  } trap_phase_e;

  // Linkage word: overflow in the top bit, forced indirect marker,
  // return address in the low bits, zero elsewhere.
  function automatic logic [WORD_W-1:0] link_word(input logic ovf,
                                                  input logic [WORD_W-1:0] ret_zx);
    logic [WORD_W-1:0] w;
    w = ret_zx;
    w[IND_BIT] = 1'b1;
    w[WORD_W-1] = ovf;
    return w;
  endfunction

  // System call qualification.
  function automatic logic is_syscall(input logic [1:0] mode, input logic top_bit);
    return (mode == MODE_USER) && top_bit;
  endfunction

endpackage

// File: rtl/pop_decode.sv
module pop_decode
  import pop_trap_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic              instr_valid,
  input  logic              stall,
  input  logic [WORD_W-1:0] instr,
  input  logic [1:0]        mode,
  output logic              accept,
  output logic              sys_call,
  output logic [OP_W-1:0]   op_num
);

  logic pop_tag;

  assign pop_tag  = instr[TAG_POP];
  assign accept   = instr_valid & ~stall & pop_tag;
  assign sys_call = is_syscall(mode, instr[TAG_SYS]);
  assign op_num   = instr[OPC_LSB +: OP_W];

endmodule

// File: rtl/pop_capture.sv
module pop_capture
  import pop_trap_pkg::*;
#(
  parameter int PC_W     = 14,
  parameter int OP_W     = 6,
  parameter int VEC_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              ovf_in,
  input  logic [OP_W-1:0]   op_in,
  input  logic              sys_in,
  output logic [WORD_W-1:0] link_data,
  output logic [PC_W-1:0]   vec_pc,
  output logic              sys_q
);

  localparam logic [PC_W-1:0] BASE_V = PC_W'(VEC_BASE);

  logic [PC_W-1:0] pc_q;
  logic            ovf_q;
  logic [OP_W-1:0] op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
      op_q  <= '0;
      sys_q <= 1'b0;
    end else if (load) begin
      pc_q  <= pc_in;
      ovf_q <= ovf_in;
      op_q  <= op_in;
      sys_q <= sys_in;
    end
  end

  assign link_data = link_word(ovf_q, WORD_W'(pc_q));
  assign vec_pc    = BASE_V + PC_W'(op_q);

endmodule

// File: rtl/pop_phase_ctl.sv
module pop_phase_ctl
  import pop_trap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic link_stb,
  output logic jump_stb
);

  trap_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_LINK;
      PH_LINK: phase_d = PH_JUMP;
      PH_JUMP: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign busy     = (phase_q != PH_IDLE);
  assign link_stb = (phase_q == PH_LINK);
  assign jump_stb = (phase_q == PH_JUMP);

  AST_LINK_THEN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    link_stb |=> jump_stb);  // R5
  AST_JUMP_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    jump_stb |=> !busy);  // R8
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);  // R8
  AST_START_TO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> link_stb);  // R1

endmodule

// File: rtl/pop_trap_seq.sv
module pop_trap_seq
  import pop_trap_pkg::*;
#(
  parameter int PC_W     = 14,
  parameter int OP_W     = 6,
  parameter int VEC_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [23:0]       instr,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              ovf_in,
  input  logic [1:0]        mode_in,
  output logic              busy,
  output logic              mem_we,
  output logic [PC_W-1:0]   mem_addr,
  output logic [23:0]       mem_wdata,
  output logic              mem_phys,
  output logic              ovf_clr,
  output logic [1:0]        mode_out,
  output logic              mode_load,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_next
);

  localparam int VEC_TOP = VEC_BASE + (1 << OP_W);

  // Named internal events
  logic              ev_accept;
  logic              ev_sys;
  logic [OP_W-1:0]   op_num;
  logic              ev_link;
  logic              ev_jump;
  logic              sys_q;
  logic [WORD_W-1:0] link_data;
  logic [PC_W-1:0]   vec_pc;

  pop_decode #(.OP_W(OP_W)) u_decode (
    .instr_valid (instr_valid),
    .stall       (busy),
    .instr       (instr),
    .mode        (mode_in),
    .accept      (ev_accept),
    .sys_call    (ev_sys),
    .op_num      (op_num)
  );

  pop_capture #(.PC_W(PC_W), .OP_W(OP_W), .VEC_BASE(VEC_BASE)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept),
    .pc_in     (pc_in),
    .ovf_in    (ovf_in),
    .op_in     (op_num),
    .sys_in    (ev_sys),
    .link_data (link_data),
    .vec_pc    (vec_pc),
    .sys_q     (sys_q)
  );

  pop_phase_ctl u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ev_accept),
    .busy     (busy),
    .link_stb (ev_link),
    .jump_stb (ev_jump)
  );

  assign mem_we    = ev_link;
  assign mem_addr  = '0;
  assign mem_wdata = ev_link ? link_data : '0;
  assign mem_phys  = ev_link & sys_q;
  assign ovf_clr   = ev_link;
  assign mode_load = ev_link & sys_q;
  assign mode_out  = mode_load ? MODE_MONITOR : 2'b00;
  assign pc_load   = ev_jump;
  assign pc_next   = ev_jump ? vec_pc : '0;

  AST_LINK_PC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[PC_W-1:0] == $past(pc_in));  // R2
  AST_LINK_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[WORD_W-1] == $past(ovf_in));  // R3
  AST_LINK_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[IND_BIT] && mem_wdata[22:15] == 8'd0);  // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (int'(pc_next) >= VEC_BASE) && (int'(pc_next) < VEC_TOP));  // R5
  AST_SYS_FROM_USER: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |-> mem_phys && $past(mode_in) == MODE_USER && $past(instr[TAG_SYS]));  // R6
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !pc_load && !mode_load);  // R9
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, pc_load}));  // R8

endmodule

// File: tb/pop_trap_seq_bench.sv
module pop_trap_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [23:0] instr;
  logic [13:0] pc_in;
  logic        ovf_in;
  logic [1:0]  mode_in;
  logic        busy, mem_we, mem_phys, ovf_clr, mode_load, pc_load;
  logic [13:0] mem_addr, pc_next;
  logic [23:0] mem_wdata;
  logic [1:0]  mode_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Reference model state
  int          m_phase = 0;
  logic [13:0] m_pc    = '0;
  logic        m_ovf   = 1'b0;
  int          m_op    = 0;
  logic        m_sys   = 1'b0;

  always #5 clk = ~clk;

  pop_trap_seq u_pop_trap_seq (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .pc_in(pc_in), .ovf_in(ovf_in), .mode_in(mode_in), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_phys(mem_phys), .ovf_clr(ovf_clr), .mode_out(mode_out),
    .mode_load(mode_load), .pc_load(pc_load), .pc_next(pc_next)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare all outputs against the model for the current cycle.
  task automatic compare_all();
    logic [23:0] exp_w;
    bit lk, jp;
    lk = (m_phase == 1);
    jp = (m_phase == 2);
    exp_w = lk ? ({m_ovf, 23'd0} | 24'h004000 | {10'd0, m_pc}) : 24'd0;
    chk("R8", "busy", busy, m_phase != 0);
    chk("R2", "mem_we", mem_we, lk);
    chk("R2", "mem_addr", mem_addr, 0);
    chk("R4", "mem_wdata", mem_wdata, exp_w);
    chk("R3", "ovf_clr", ovf_clr, lk);
    chk("R6", "mode_load", mode_load, lk && m_sys);
    chk("R7", "mode_out", mode_out, (lk && m_sys) ? 1 : 0);
    chk("R6", "mem_phys", mem_phys, lk && m_sys);
    chk("R5", "pc_load", pc_load, jp);
    chk("R5", "pc_next", pc_next, jp ? 64 + m_op : 0);
  endtask

  // One cycle: check at negedge, drive, advance model for next posedge.
  task automatic step(input bit v, input logic [23:0] ins, input logic [13:0] pc,
                      input bit ov, input logic [1:0] md);
    @(negedge clk);
    compare_all();
    instr_valid = v; instr = ins; pc_in = pc; ovf_in = ov; mode_in = md;
    if (m_phase == 0) begin
      if (v && ins[21]) begin
        m_phase = 1; m_pc = pc; m_ovf = ov; m_op = int'(ins[20:15]);
        m_sys = (md == 2'b10) && ins[23];
      end
    end else if (m_phase == 1) m_phase = 2;
    else m_phase = 0;
  endtask

  function automatic logic [23:0] mk(input bit top, input bit pop, input int op, input int addr);
    return {top, 1'b0, pop, 6'(op), 1'b0, 14'(addr)};
  endfunction

  initial begin
    rst_n = 1'b0; instr_valid = 0; instr = '0; pc_in = '0; ovf_in = 0; mode_in = 0;
    #23;
    // R10: reset state
    chk("R10", "busy", busy, 0);
    chk("R10", "mem_we", mem_we, 0);
    chk("R10", "pc_load", pc_load, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1 R3: normal mode trap with overflow set, op 5
    step(1, mk(0, 1, 5, 123), 14'h0100, 1, 2'b00);
    step(0, 0, 0, 0, 2'b00); step(0, 0, 0, 0, 2'b00); step(0, 0, 0, 0, 2'b00);
    // R6: user mode system call, op 63 (top slot)
    step(1, mk(1, 1, 63, 7), 14'h3fff, 0, 2'b10);
    step(0, 0, 0, 0, 2'b10); step(0, 0, 0, 0, 2'b10); step(0, 0, 0, 0, 2'b10);
    // R7: user ordinary operator, op 0 (bottom slot)
    step(1, mk(0, 1, 0, 1), 14'h0001, 1, 2'b10);
    step(0, 0, 0, 0, 2'b10); step(0, 0, 0, 0, 2'b10);
    // R7: monitor / reserved modes with top bit set
    step(1, mk(1, 1, 17, 0), 14'h0222, 0, 2'b01);
    step(0, 0, 0, 0, 2'b01); step(0, 0, 0, 0, 2'b01);
    step(1, mk(1, 1, 40, 0), 14'h0333, 1, 2'b11);
    step(0, 0, 0, 0, 2'b11); step(0, 0, 0, 0, 2'b11);
    // R9: non-operator in user mode with top bit set
    step(1, mk(1, 0, 33, 9), 14'h0444, 1, 2'b10);
    step(1, mk(0, 0, 12, 9), 14'h0445, 0, 2'b00);
    // R8: requests during busy are ignored, back-to-back traps
    step(1, mk(0, 1, 9, 0), 14'h0500, 0, 2'b00);
    step(1, mk(1, 1, 50, 0), 14'h0501, 1, 2'b10);
    step(1, mk(1, 1, 51, 0), 14'h0502, 1, 2'b10);
    step(1, mk(1, 1, 52, 0), 14'h0503, 1, 2'b10);
    step(0, 0, 0, 0, 2'b00); step(0, 0, 0, 0, 2'b00); step(0, 0, 0, 0, 2'b00);
    // Pseudorandom sweep
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] r;
      r = 24'($urandom);
      step(1'($urandom), r, 14'($urandom), 1'($urandom), 2'($urandom));
    end
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule